// File: doc/BRIEF.md
# Power-On Strap Capture and Frequency Code Selector

This block keeps the configuration that a board sets with pull resistors on five pins that later carry clocks. While power-on reset is held, the block samples those pins on every clock edge, so its copy always follows the pin levels. When reset is released, the copy freezes. On the next edge the block asserts the output enables, and from then on the pins drive clocks. Four of the five captured bits form the frequency code. The fifth selects the rate of one clock output.

A control byte, written by a register file outside this block, picks where the frequency code comes from. It can come from the frozen straps, or from four bits of the control byte that are not next to each other. The block registers the chosen code and sends it to the PLL control. It also raises a pulse for one cycle whenever that code changes. It decodes the spread-spectrum enable and mode bits from the same byte. It also provides the captured straps as a read-only status byte, so software can read them back. The frequency table and the PLL itself sit outside this block.

Top module: `freq_strap_sel`

## Requirements
- R1: While `rst_n` is low, the strap copy takes the pin levels on every rising edge. In that time `fsel_o` equals `strap_pin_i[3:0]` one edge later, whatever `cfg_i` holds. `strap_oe_o`, `fsel_upd_o`, `ss_en_o` and `ss_down_o` are all 0.
- R2: The strap copy holds the pin levels from the last rising edge at which `rst_n` was low. After that, pin changes have no effect on `strap_stat_o`, `rate_sel_o` or the straps-sourced code.
- R3: Starting at the first rising edge with `rst_n` high, every bit of `strap_oe_o` is 1, and it stays 1 until the next reset.
- R4: With `cfg_i[3]` = 0, `fsel_o` takes the latched strap bits [3:0] one edge later. The code bits of `cfg_i` have no effect.
- R5: With `cfg_i[3]` = 1, `fsel_o` takes a code from `cfg_i` one edge later. Code bit 0 is `cfg_i[2]`, code bit 1 is `cfg_i[4]`, code bit 2 is `cfg_i[5]` and code bit 3 is `cfg_i[6]`.
- R6: `strap_stat_o` shows the latched frequency straps in bits [3:0] and the latched rate strap in bit 4. Bits [7:5] read 0.
- R7: `rate_sel_o` equals the latched strap bit 4 (pin `strap_pin_i[4]`).
- R8: Outside reset, `ss_en_o` follows `cfg_i[1]` and `ss_down_o` follows `cfg_i[7]`, each one edge later. A 1 on `ss_down_o` asks for down spread of 0 to -0.5%. A 0 asks for center spread of ±0.25%.
- R9: `fsel_upd_o` is 1 for exactly the cycle in which `fsel_o` has just taken a value different from its previous one. In every other cycle it is 0, and that includes the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low; straps are sampled while it is low |
| strap_pin_i | input | 5 | Input levels of the shared pins: [3:0] frequency straps, [4] rate strap |
| cfg_i | input | 8 | Control byte: [3] source select, [6,5,4,2] register code, [1] spread enable, [7] spread mode |
| strap_oe_o | output | 5 | Output enables for the shared pins |
| strap_stat_o | output | 8 | Read-only status byte holding the latched straps |
| rate_sel_o | output | 1 | Latched output-rate strap |
| fsel_o | output | 4 | Selected frequency code toward the PLL control |
| fsel_upd_o | output | 1 | One-cycle pulse when the selected code changes |
| ss_en_o | output | 1 | Spread-spectrum enable |
| ss_down_o | output | 1 | Spread mode: 1 down spread, 0 center spread |

## Verification
Some rules hold on every cycle, and assertions check those: the strap copy stays frozen outside reset, the enables are high after reset, the straps-sourced path follows the copy, the update pulse matches a change of code, and the spread bits follow the control byte. Other behaviour shows only through the bench's scenarios. These include the bit order of the register-sourced code, the status byte layout for each of the 32 strap patterns, and the fact that the pins go on changing during reset but have no effect once it ends. The same holds for the way the code follows the pins inside the reset window, and for the absence of a pulse when the source switches but the value stays the same.

// File: rtl/fss_pkg.sv
package fss_pkg;
  localparam int FS_W   = 4;
  localparam int STAT_W = 8;

  typedef logic [FS_W-1:0] fs_code_t;

  // Register-sourced code: bit 0 from cfg[2], bits 3:1 from cfg[6:4].
  function automatic fs_code_t cfg_to_code(input logic [7:0] cfg);
    return {cfg[6], cfg[5], cfg[4], cfg[2]};
  endfunction

  // Status byte: latched straps in the low bits, zeros above.
  function automatic logic [STAT_W-1:0] pack_status(input logic [FS_W:0] s);
    logic [STAT_W-1:0] r;
    r = '0;
    r[FS_W:0] = s;
    return r;
  endfunction
endpackage

// File: rtl/fss_strap_latch.sv
module fss_strap_latch #(
  parameter int STRAP_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] pin_i,
  output logic [STRAP_W-1:0] strap_o,
  output logic [STRAP_W-1:0] oe_o,
  output logic               por_done_o
);
  logic [STRAP_W-1:0] strap_q;
  logic               por_q;

  // Sample every edge while reset is held; freeze once it is released.
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= pin_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) por_q <= 1'b0;
    else        por_q <= 1'b1;
  end

  for (genvar i = 0; i < STRAP_W; i++) begin : g_oe
    assign oe_o[i] = por_q;
  end

  assign strap_o    = strap_q;
  assign por_done_o = por_q;

  // R2
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_q));

  // R3
  oe_after_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (oe_o == {STRAP_W{1'b1}}));
endmodule

// File: rtl/fss_code_mux.sv
module fss_code_mux
  import fss_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  fs_code_t pin_code_i,
  input  fs_code_t strap_code_i,
  input  fs_code_t reg_code_i,
  input  logic     use_reg_i,
  output fs_code_t fsel_o,
  output logic     upd_o
);
  fs_code_t fsel_q;
  fs_code_t fsel_next;
  logic     upd_q;
  logic     code_change;

  assign fsel_next   = use_reg_i ? reg_code_i : strap_code_i;
  assign code_change = (fsel_next != fsel_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsel_q <= pin_code_i;
      upd_q  <= 1'b0;
    end else begin
      fsel_q <= fsel_next;
      upd_q  <= code_change;
    end
  end

  assign fsel_o = fsel_q;
  assign upd_o  = upd_q;

  // R4
  strap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(use_reg_i)) |-> (fsel_q == $past(strap_code_i)));

  // R5
  reg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(use_reg_i)) |-> (fsel_q == $past(reg_code_i)));

  // R9
  upd_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> !$stable(fsel_q));

  // R9
  change_has_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(fsel_q)) |-> upd_q);
endmodule

// File: rtl/fss_ss_decode.sv
module fss_ss_decode #(
  parameter int CFG_W   = 8,
  parameter int EN_BIT  = 1,
  parameter int MODE_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             ss_en_o,
  output logic             ss_down_o
);
  logic en_q, down_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      down_q <= 1'b0;
    end else begin
      en_q   <= cfg_i[EN_BIT];
      down_q <= cfg_i[MODE_BIT];
    end
  end

  assign ss_en_o   = en_q;
  assign ss_down_o = down_q;

  // R8
  ss_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ss_en_o == $past(cfg_i[EN_BIT]) && ss_down_o == $past(cfg_i[MODE_BIT])));
endmodule

// File: rtl/freq_strap_sel.sv
module freq_strap_sel
  import fss_pkg::*;
#(
  parameter int SRC_BIT     = 3,
  parameter int SS_EN_BIT   = 1,
  parameter int SS_MODE_BIT = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [FS_W:0]        strap_pin_i,
  input  logic [7:0]           cfg_i,
  output logic [FS_W:0]        strap_oe_o,
  output logic [STAT_W-1:0]    strap_stat_o,
  output logic                 rate_sel_o,
  output logic [FS_W-1:0]      fsel_o,
  output logic                 fsel_upd_o,
  output logic                 ss_en_o,
  output logic                 ss_down_o
);
  localparam int STRAP_W = FS_W + 1;

  logic [STRAP_W-1:0] strap_q;
  logic               por_done;
  fs_code_t           reg_code;
  logic               unused_cfg;

  assign unused_cfg = cfg_i[0];
  assign reg_code   = cfg_to_code(cfg_i);

  fss_strap_latch #(.STRAP_W(STRAP_W)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (strap_pin_i),
    .strap_o    (strap_q),
    .oe_o       (strap_oe_o),
    .por_done_o (por_done)
  );

  fss_code_mux u_mux (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_code_i   (strap_pin_i[FS_W-1:0]),
    .strap_code_i (strap_q[FS_W-1:0]),
    .reg_code_i   (reg_code),
    .use_reg_i    (cfg_i[SRC_BIT]),
    .fsel_o       (fsel_o),
    .upd_o        (fsel_upd_o)
  );

  fss_ss_decode #(.CFG_W(8), .EN_BIT(SS_EN_BIT), .MODE_BIT(SS_MODE_BIT)) u_ss (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_i     (cfg_i),
    .ss_en_o   (ss_en_o),
    .ss_down_o (ss_down_o)
  );

  assign strap_stat_o = pack_status(strap_q);
  assign rate_sel_o   = strap_q[FS_W];

  // R1
  quiet_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !por_done |-> (!fsel_upd_o && !ss_en_o && !ss_down_o));

  // R6
  stat_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strap_stat_o[STAT_W-1:STRAP_W] == '0);

  // R7
  rate_matches_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_sel_o == strap_stat_o[FS_W]);
endmodule

// File: tb/freq_strap_sel_bench.sv
module freq_strap_sel_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] pins;
  logic [7:0] cfg;
  logic [4:0] oe;
  logic [7:0] stat;
  logic       rate, upd, ss_en, ss_down;
  logic [3:0] fsel;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  freq_strap_sel u_freq_strap_sel (
    .clk(clk), .rst_n(rst_n), .strap_pin_i(pins), .cfg_i(cfg),
    .strap_oe_o(oe), .strap_stat_o(stat), .rate_sel_o(rate),
    .fsel_o(fsel), .fsel_upd_o(upd), .ss_en_o(ss_en), .ss_down_o(ss_down)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Register code c placed at bits 2,4,5,6; source select at bit 3.
  function automatic logic [7:0] code_cfg(input int c, input bit src);
    return 8'((src ? 8 : 0) + (c % 2) * 4 + (c / 2) * 16);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int prev;
    rst_n = 1'b0; pins = '0; cfg = 8'hFF;
    for (int p = 0; p < 32; p++) begin
      @(negedge clk); rst_n = 1'b0; pins = 5'(p); cfg = 8'hFF;
      @(negedge clk);
      @(negedge clk);
      chk("R1 code follows pins in reset", fsel, p % 16);
      chk("R1 oe low in reset", oe, 0);
      chk("R1 no pulse in reset", upd, 0);
      chk("R1 spread off in reset", {ss_en, ss_down}, 0);
      pins = 5'(p ^ 5);
      @(negedge clk);
      chk("R1 transparent in reset", fsel, (p ^ 5) % 16);
      pins = 5'(p);
      @(negedge clk);
      // release: straps frozen at p, pins now differ, register code differs
      rst_n = 1'b1; pins = 5'(~p); cfg = 8'h74;
      @(negedge clk);
      chk("R3 oe high after reset", oe, 31);
      chk("R6 status byte", stat, p);
      chk("R4 code from straps", fsel, p % 16);
      chk("R7 rate strap", rate, p / 16);
      chk("R9 no pulse first cycle", upd, 0);
      pins = 5'(p ^ 31);
      @(negedge clk);
      chk("R2 straps frozen", stat, p);
      chk("R2 code unchanged", fsel, p % 16);
      chk("R3 oe stays high", oe, 31);
    end
    prev = 15;
    for (int c = 0; c < 16; c++) begin
      logic [7:0] v;
      v = code_cfg(c, 1'b1);
      v[1] = c[1];
      v[7] = c[2];
      cfg = v;
      @(negedge clk);
      chk("R5 register code", fsel, c);
      chk("R9 pulse on change", upd, (c != prev) ? 1 : 0);
      chk("R8 spread enable", ss_en, c / 2 % 2);
      chk("R8 spread mode", ss_down, c / 4 % 2);
      @(negedge clk);
      chk("R9 single pulse", upd, 0);
      chk("R5 code held", fsel, c);
      prev = c;
    end
    cfg = code_cfg(3, 1'b0);
    @(negedge clk);
    chk("R4 back to straps", fsel, 15);
    chk("R9 no pulse same value", upd, 0);
    cfg = code_cfg(0, 1'b1);
    @(negedge clk);
    chk("R5 switch to register", fsel, 0);
    chk("R9 pulse on switch", upd, 1);
    @(negedge clk);
    chk("R9 pulse ends", upd, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule